// File: doc/BRIEF.md
# AXI-Lite Width Down-Converter

This block joins a wide AXI-Lite master port to a narrower AXI-Lite slave port. The narrow data width must divide the wide width by a power of two. A wide write is broken into narrow writes, one per narrow lane, lowest lane first, and each carries its own slice of the wide data and strobe. A wide read is broken into narrow reads in the same order, and the returned pieces are packed back into one wide data word.

Writes and reads go through two separate state machines that share no state. A read can therefore be in progress on the slave side while a write is also in progress. Each wide transaction gets exactly one response. That response is OKAY only if every narrow beat answered OKAY. Otherwise it carries the first non-OKAY code that came back.

Top module: `axil_downsizer`

## Requirements
- R1: A wide transfer at address A becomes up to N = WIDE_W/NARROW_W narrow transfers. They are issued in lane order 0 first. Lane k uses address A + k*(NARROW_W/8), so 32-to-16 gives A then A+2.
- R2: The narrow write for lane k carries bits [k*NARROW_W +: NARROW_W] of the wide data. Its strobe is bits [k*NARROW_W/8 +: NARROW_W/8] of the wide strobe.
- R3: A lane whose strobe slice is all zero issues no narrow write, and no narrow write ever has an all-zero strobe. For example, strobe 4'b1100 at 32-to-16 issues only the beat at A+2.
- R4: A wide write whose whole strobe is zero issues no narrow beat and completes with response 2'b00 (OKAY).
- R5: The data of narrow read beat k is placed at bits [k*NARROW_W +: NARROW_W] of the wide read data.
- R6: Response codes are 2'b00 OKAY, 2'b10 SLVERR and 2'b11 DECERR. The wide response is 2'b00 only if all narrow responses of that transaction are 2'b00. Otherwise it is the first non-zero narrow response received.
- R7: Every valid output keeps its payload stable and stays asserted until its ready is seen. After reset, all valid outputs are low.
- R8: For each narrow write, address valid and write-data valid rise in the same cycle. No new narrow write is presented until the write response of the previous one has been taken.
- R9: The write path and the read path progress independently. A read may be outstanding on the slave side while a write is also outstanding.
- R10: A wide write is accepted only in a cycle where both address valid and write-data valid are present. The address ready and write ready are then high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | AW | Wide write address |
| s_awvalid | input | 1 | Wide write address valid |
| s_awready | output | 1 | Wide write address ready |
| s_wdata | input | WIDE_W | Wide write data |
| s_wstrb | input | WIDE_W/8 | Wide write strobe |
| s_wvalid | input | 1 | Wide write data valid |
| s_wready | output | 1 | Wide write data ready |
| s_bresp | output | 2 | Wide write response |
| s_bvalid | output | 1 | Wide write response valid |
| s_bready | input | 1 | Wide write response ready |
| s_araddr | input | AW | Wide read address |
| s_arvalid | input | 1 | Wide read address valid |
| s_arready | output | 1 | Wide read address ready |
| s_rdata | output | WIDE_W | Gathered wide read data |
| s_rresp | output | 2 | Wide read response |
| s_rvalid | output | 1 | Wide read valid |
| s_rready | input | 1 | Wide read ready |
| m_awaddr | output | AW | Narrow write address |
| m_awvalid | output | 1 | Narrow write address valid |
| m_awready | input | 1 | Narrow write address ready |
| m_wdata | output | NARROW_W | Narrow write data |
| m_wstrb | output | NARROW_W/8 | Narrow write strobe |
| m_wvalid | output | 1 | Narrow write data valid |
| m_wready | input | 1 | Narrow write data ready |
| m_bresp | input | 2 | Narrow write response |
| m_bvalid | input | 1 | Narrow write response valid |
| m_bready | output | 1 | Narrow write response ready |
| m_araddr | output | AW | Narrow read address |
| m_arvalid | output | 1 | Narrow read address valid |
| m_arready | input | 1 | Narrow read address ready |
| m_rdata | input | NARROW_W | Narrow read data |
| m_rresp | input | 2 | Narrow read response |
| m_rvalid | input | 1 | Narrow read valid |
| m_rready | output | 1 | Narrow read ready |

## Verification
The write splitter and the read splitter can both be mid-transaction on the slave side in the same cycle. The test provokes this by starting a stream of wide writes and a stream of wide reads at the same moment. The slave model rotates its ready and response latencies, so the two paths drift in and out of step.

Two things are judged. First, every narrow beat's address, data and strobe still arrive in lane order on each path, and every gathered word and response matches the scoreboard. Second, the test counts cycles in which a write beat and a read beat are outstanding at the same time, and requires that count to be non-zero.

// File: rtl/axil_downsizer.sv
`timescale 1ns/1ps
module axil_downsizer #(
  parameter int AW       = 32,
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         s_awaddr,
  input  logic                  s_awvalid,
  output logic                  s_awready,
  input  logic [WIDE_W-1:0]     s_wdata,
  input  logic [WIDE_W/8-1:0]   s_wstrb,
  input  logic                  s_wvalid,
  output logic                  s_wready,
  output logic [1:0]            s_bresp,
  output logic                  s_bvalid,
  input  logic                  s_bready,
  input  logic [AW-1:0]         s_araddr,
  input  logic                  s_arvalid,
  output logic                  s_arready,
  output logic [WIDE_W-1:0]     s_rdata,
  output logic [1:0]            s_rresp,
  output logic                  s_rvalid,
  input  logic                  s_rready,
  output logic [AW-1:0]         m_awaddr,
  output logic                  m_awvalid,
  input  logic                  m_awready,
  output logic [NARROW_W-1:0]   m_wdata,
  output logic [NARROW_W/8-1:0] m_wstrb,
  output logic                  m_wvalid,
  input  logic                  m_wready,
  input  logic [1:0]            m_bresp,
  input  logic                  m_bvalid,
  output logic                  m_bready,
  output logic [AW-1:0]         m_araddr,
  output logic                  m_arvalid,
  input  logic                  m_arready,
  input  logic [NARROW_W-1:0]   m_rdata,
  input  logic [1:0]            m_rresp,
  input  logic                  m_rvalid,
  output logic                  m_rready
);
  localparam int N  = WIDE_W / NARROW_W;
  localparam int NB = NARROW_W / 8;
  localparam int BW = (N > 1) ? $clog2(N) : 1;
  localparam int SH = $clog2(NB);
  localparam logic [BW-1:0] LAST = BW'(N - 1);

  typedef enum logic [2:0] {W_IDLE, W_SCAN, W_XFER, W_BWAIT, W_DONE} wst_t;
  typedef enum logic [1:0] {R_IDLE, R_ADDR, R_DATA, R_DONE} rst_t;

  wst_t                 wst;
  logic [AW-1:0]        w_addr;
  logic [WIDE_W-1:0]    w_data;
  logic [WIDE_W/8-1:0]  w_strb;
  logic [BW-1:0]        w_beat;
  logic [1:0]           w_err;
  logic                 aw_pend, w_pend;
  logic [NB-1:0]        w_slice;
  logic                 w_last;

  assign w_slice = w_strb[w_beat*NB +: NB];
  assign w_last  = (w_beat == LAST);

  assign s_awready = (wst == W_IDLE) && s_awvalid && s_wvalid;
  assign s_wready  = s_awready;
  assign s_bvalid  = (wst == W_DONE);
  assign s_bresp   = w_err;
  assign m_awvalid = (wst == W_XFER) && aw_pend;
  assign m_wvalid  = (wst == W_XFER) && w_pend;
  assign m_awaddr  = w_addr + (AW'(w_beat) << SH);
  assign m_wdata   = w_data[w_beat*NARROW_W +: NARROW_W];
  assign m_wstrb   = w_slice;
  assign m_bready  = (wst == W_BWAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wst     <= W_IDLE;
      w_addr  <= '0;
      w_data  <= '0;
      w_strb  <= '0;
      w_beat  <= '0;
      w_err   <= 2'b00;
      aw_pend <= 1'b0;
      w_pend  <= 1'b0;
    end else begin
      case (wst)
        W_IDLE: if (s_awvalid && s_wvalid) begin
          w_addr <= s_awaddr;
          w_data <= s_wdata;
          w_strb <= s_wstrb;
          w_beat <= '0;
          w_err  <= 2'b00;
          wst    <= W_SCAN;
        end
        W_SCAN: begin
          if (|w_slice) begin
            aw_pend <= 1'b1;
            w_pend  <= 1'b1;
            wst     <= W_XFER;
          end else if (w_last) begin
            wst <= W_DONE;
          end else begin
            w_beat <= w_beat + 1'b1;
          end
        end
        W_XFER: begin
          if (m_awready) aw_pend <= 1'b0;
          if (m_wready)  w_pend  <= 1'b0;
          if ((!aw_pend || m_awready) && (!w_pend || m_wready)) wst <= W_BWAIT;
        end
        W_BWAIT: if (m_bvalid) begin
          if (w_err == 2'b00) w_err <= m_bresp;
          if (w_last) wst <= W_DONE;
          else begin
            w_beat <= w_beat + 1'b1;
            wst    <= W_SCAN;
          end
        end
        W_DONE: if (s_bready) wst <= W_IDLE;
        default: wst <= W_IDLE;
      endcase
    end
  end

  rst_t                 rst;
  logic [AW-1:0]        r_addr;
  logic [BW-1:0]        r_beat;
  logic [1:0]           r_err;
  logic [WIDE_W-1:0]    r_buf;

  assign s_arready = (rst == R_IDLE);
  assign s_rvalid  = (rst == R_DONE);
  assign s_rdata   = r_buf;
  assign s_rresp   = r_err;
  assign m_arvalid = (rst == R_ADDR);
  assign m_araddr  = r_addr + (AW'(r_beat) << SH);
  assign m_rready  = (rst == R_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst    <= R_IDLE;
      r_addr <= '0;
      r_beat <= '0;
      r_err  <= 2'b00;
      r_buf  <= '0;
    end else begin
      case (rst)
        R_IDLE: if (s_arvalid) begin
          r_addr <= s_araddr;
          r_beat <= '0;
          r_err  <= 2'b00;
          rst    <= R_ADDR;
        end
        R_ADDR: if (m_arready) rst <= R_DATA;
        R_DATA: if (m_rvalid) begin
          r_buf[r_beat*NARROW_W +: NARROW_W] <= m_rdata;
          if (r_err == 2'b00) r_err <= m_rresp;
          if (r_beat == LAST) rst <= R_DONE;
          else begin
            r_beat <= r_beat + 1'b1;
            rst    <= R_ADDR;
          end
        end
        R_DONE: if (s_rready) rst <= R_IDLE;
        default: rst <= R_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/axil_downsizer_chk.sv
`timescale 1ns/1ps
module axil_downsizer_chk #(
  parameter int AW       = 32,
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  s_awvalid,
  input logic                  s_wvalid,
  input logic                  s_awready,
  input logic                  s_wready,
  input logic [1:0]            s_bresp,
  input logic                  s_bvalid,
  input logic                  s_bready,
  input logic [WIDE_W-1:0]     s_rdata,
  input logic [1:0]            s_rresp,
  input logic                  s_rvalid,
  input logic                  s_rready,
  input logic [AW-1:0]         m_awaddr,
  input logic                  m_awvalid,
  input logic                  m_awready,
  input logic [NARROW_W-1:0]   m_wdata,
  input logic [NARROW_W/8-1:0] m_wstrb,
  input logic                  m_wvalid,
  input logic                  m_wready,
  input logic                  m_bvalid,
  input logic                  m_bready,
  input logic [AW-1:0]         m_araddr,
  input logic                  m_arvalid,
  input logic                  m_arready
);
  p_aw_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr));
  p_w_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata) && $stable(m_wstrb));
  p_ar_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr));
  p_b_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid && $stable(s_bresp));
  p_r_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata) && $stable(s_rresp));
  p_strb_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid |-> (m_wstrb != '0));
  p_pair_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_awvalid) |-> $rose(m_wvalid));
  p_no_beat_in_bwait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    m_bready |-> !m_awvalid && !m_wvalid);
  p_accept_both_r10: assert property (@(posedge clk) disable iff (!rst_n)
    s_awready |-> s_awvalid && s_wvalid && s_wready);
endmodule

bind axil_downsizer axil_downsizer_chk #(.AW(AW), .WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_chk (.*);

// File: tb/sim_axil_downsizer.sv
`timescale 1ns/1ps
module sim_axil_downsizer;
  localparam int AW = 32, WW = 32, NW = 16, NB = NW/8, N = WW/NW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0] s_awaddr = '0, s_araddr = '0;
  logic s_awvalid = 0, s_wvalid = 0, s_bready = 1, s_arvalid = 0, s_rready = 1;
  logic [WW-1:0] s_wdata = '0;
  logic [WW/8-1:0] s_wstrb = '0;
  logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0] s_bresp, s_rresp;
  logic [WW-1:0] s_rdata;
  logic [AW-1:0] m_awaddr, m_araddr;
  logic m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready;
  logic [NW-1:0] m_wdata;
  logic [NB-1:0] m_wstrb;
  logic m_awready = 0, m_wready = 0, m_bvalid = 0, m_arready = 0, m_rvalid = 0;
  logic [1:0] m_bresp = 0, m_rresp = 0;
  logic [NW-1:0] m_rdata = '0;

  axil_downsizer #(.AW(AW), .WIDE_W(WW), .NARROW_W(NW)) u0 (.*);

  int nvec = 0, nfail = 0, overlap = 0;
  logic [49:0] wq[$];
  logic [31:0] arq[$];
  logic [1:0]  bq[$];
  logic [33:0] rq[$];

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [1:0] errmap(input logic [31:0] a);
    case (a)
      32'h200: return 2'b11;
      32'h202: return 2'b10;
      32'h302: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [NW-1:0] rdfn(input logic [31:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  task automatic do_write(input logic [31:0] a, input logic [WW-1:0] d, input logic [WW/8-1:0] s);
    logic [1:0] e = 2'b00;
    for (int k = 0; k < N; k++) begin
      logic [NB-1:0] sl = s[k*NB +: NB];
      if (sl != 0) begin
        wq.push_back({a + 32'(k*NB), d[k*NW +: NW], sl});
        if (e == 2'b00) e = errmap(a + 32'(k*NB));
      end
    end
    bq.push_back(e);
    @(negedge clk);
    s_awaddr = a; s_wdata = d; s_wstrb = s; s_awvalid = 1; s_wvalid = 1;
    #1;
    while (!s_awready) begin @(negedge clk); #1; end
    check("R10 wready with awready", {63'd0, s_wready}, 64'd1);
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 0;
    while (bq.size() != 0) @(negedge clk);
  endtask

  task automatic do_read(input logic [31:0] a);
    logic [1:0] e = 2'b00;
    logic [WW-1:0] d = '0;
    for (int k = 0; k < N; k++) begin
      arq.push_back(a + 32'(k*NB));
      d[k*NW +: NW] = rdfn(a + 32'(k*NB));
      if (e == 2'b00) e = errmap(a + 32'(k*NB));
    end
    rq.push_back({e, d});
    @(negedge clk);
    s_araddr = a; s_arvalid = 1;
    #1;
    while (!s_arready) begin @(negedge clk); #1; end
    @(negedge clk);
    s_arvalid = 0;
    while (rq.size() != 0) @(negedge clk);
  endtask

  int wlat = 0, rlat = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && m_awvalid && m_wvalid) begin
        logic [31:0] a; logic [NW-1:0] d; logic [NB-1:0] s; logic [49:0] e;
        wlat = (wlat + 1) % 3;
        repeat (wlat) @(negedge clk);
        check("R7 write valid held", {62'd0, m_awvalid, m_wvalid}, 64'd3);
        a = m_awaddr; d = m_wdata; s = m_wstrb;
        m_awready = 1; m_wready = 1;
        @(negedge clk);
        m_awready = 0; m_wready = 0;
        if (wq.size() == 0) begin
          nvec++; nfail++;
          $display("FAIL R3: unexpected narrow write got %0h expected none", a);
        end else begin
          e = wq.pop_front();
          check("R1 write address", {32'd0, a}, {32'd0, e[49:18]});
          check("R2 write data/strobe", {46'd0, d, s}, {46'd0, e[17:0]});
        end
        check("R8 no new beat before response", {63'd0, m_awvalid}, 64'd0);
        repeat (wlat) @(negedge clk);
        m_bvalid = 1; m_bresp = errmap(a);
        @(negedge clk);
        m_bvalid = 0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && m_arvalid) begin
        logic [31:0] a;
        rlat = (rlat + 2) % 3;
        repeat (rlat) @(negedge clk);
        a = m_araddr;
        m_arready = 1;
        @(negedge clk);
        m_arready = 0;
        if (arq.size() == 0) begin
          nvec++; nfail++;
          $display("FAIL R1: unexpected narrow read got %0h expected none", a);
        end else check("R1 read address", {32'd0, a}, {32'd0, arq.pop_front()});
        repeat (rlat) @(negedge clk);
        m_rvalid = 1; m_rdata = rdfn(a); m_rresp = errmap(a);
        @(negedge clk);
        m_rvalid = 0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (m_awvalid || m_bready) && (m_arvalid || m_rready)) overlap++;
      if (rst_n && s_bvalid) begin
        if (bq.size() == 0) begin nvec++; nfail++; $display("FAIL R6: unexpected write response got %0h expected none", s_bresp); end
        else check("R4/R6 write response", {62'd0, s_bresp}, {62'd0, bq.pop_front()});
      end
      if (rst_n && s_rvalid) begin
        if (rq.size() == 0) begin nvec++; nfail++; $display("FAIL R5: unexpected read response got %0h expected none", s_rdata); end
        else check("R5/R6 read data and response", {30'd0, s_rresp, s_rdata}, {30'd0, rq.pop_front()});
      end
    end
  end

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset valids low", {59'd0, m_awvalid, m_wvalid, m_arvalid, s_bvalid, s_rvalid}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    s_awaddr = 32'h40; s_awvalid = 1;
    repeat (4) begin
      @(negedge clk);
      check("R10 no accept without write data", {62'd0, s_awready, m_awvalid}, 64'd0);
    end
    s_awvalid = 0;
    do_write(32'h0,   32'h22221111, 4'hF);
    do_write(32'h4,   32'h44443333, 4'hF);
    do_write(32'h100, 32'h88887777, 4'hF);
    do_write(32'h0,   32'hAAAA9999, 4'b1100);
    do_write(32'h8,   32'h66665555, 4'b1011);
    do_write(32'h100, 32'hCCCCBBBB, 4'b0011);
    do_write(32'h40,  32'hDEADBEEF, 4'b0000);
    check("R4 no beats left pending", {32'd0, 32'(wq.size())}, 64'd0);
    do_write(32'h200, 32'h12345678, 4'hF);
    do_write(32'h300, 32'h9ABCDEF0, 4'hF);
    do_write(32'h200, 32'h0000FFFF, 4'b1100);
    do_read(32'h0);
    do_read(32'h4);
    do_read(32'h100);
    do_read(32'h200);
    do_read(32'h300);
    fork
      begin
        do_write(32'h10, 32'h11112222, 4'hF);
        do_write(32'h14, 32'h33334444, 4'b0110);
        do_write(32'h18, 32'h55556666, 4'hF);
        do_write(32'h300, 32'h77778888, 4'hF);
      end
      begin
        do_read(32'h20);
        do_read(32'h24);
        do_read(32'h202);
        do_read(32'h28);
      end
    join
    repeat (10) @(negedge clk);
    check("R9 write and read outstanding together", {63'd0, overlap > 0}, 64'd1);
    check("R1 all expected narrow beats seen", {32'd0, 32'(wq.size() + arq.size())}, 64'd0);
    finish_run();
  end
endmodule